// File: doc/BRIEF.md
# Watchdog Timer with Mode Register

This block is the watchdog counter chain of a small microcontroller. After reset it stays idle until software issues its first refresh strobe; from then on it counts edges of one of two slow time bases (an internal oscillator or an external clock pin). Every later refresh restarts the count. If the count reaches the selected time-out before a refresh arrives, the block raises a reset request for one system clock cycle.

A 5-bit mode register sets the time-out length, whether counting continues while the processor is in its HALT or STOP low-power state, and which time base is used. A strap input selects a permanent mode. In that mode the watchdog is live from reset and uses a fixed time-out. It counts in HALT, and it counts in STOP only when the internal oscillator is the time base. In permanent mode the register's timing and gating bits have no effect.

The whole block runs on the system clock. Both time-base inputs pass through a two-flop synchroniser followed by a rising-edge detector. Each rising edge of the selected time base is one count step.

Top module: `wdog_ctl`

## Requirements
- R1: Outside permanent mode, the watchdog does not count after reset until the first refresh strobe. After it issues a reset request it returns to this idle state, and it issues no further request until it is refreshed again.
- R2: A refresh strobe restarts the count from zero. The full time-out must then elapse again before a request is issued.
- R3: Mode bits [1:0] select the time-out in counted edges: 00 gives 128, 01 gives 256, 10 gives 512 and 11 gives 2048. The request follows the edge that completes that number.
- R4: After reset, `mode_rdata` reads 5'b00101. This means a tap of 01, bit 2 set, and bits 3 and 4 clear.
- R5: Mode bit 4 selects the time base: 0 selects `rc_clk_in` and 1 selects `ext_clk_in`. Edges on the time base that is not selected are not counted.
- R6: While `halt` is high and `stop` is low, the watchdog counts only if mode bit 2 is 1. If bit 2 is 0, the count is frozen.
- R7: While `stop` is high, the watchdog counts only when bit 4 is 0 and bit 3 is 1. The STOP rule takes precedence over the HALT rule.
- R8: With `perm_strap` high, the watchdog is armed from reset and needs no refresh. It uses a fixed time-out of 256 edges, counts in HALT, and ignores mode bits [3:0]. In STOP it counts only when bit 4 is 0. After each request it stays armed.
- R9: `wdog_rst_req` is high for exactly one system clock cycle per time-out.
- R10: Outside permanent mode, a register write that changes bits [1:0] clears the count. A write that leaves bits [1:0] unchanged does not clear it.
- R11: A refresh in the same cycle as the edge that would complete the time-out wins. No request is issued, and the count restarts.
- R12: A time-base input held high for many system cycles counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_clk_in | input | 1 | Internal oscillator time base |
| ext_clk_in | input | 1 | External clock pin time base |
| perm_strap | input | 1 | Permanent-mode strap, static after reset |
| refresh | input | 1 | One-cycle refresh strobe |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 5 | Mode register write data |
| halt | input | 1 | Processor is in HALT |
| stop | input | 1 | Processor is in STOP |
| mode_rdata | output | 5 | Mode register contents |
| wdog_rst_req | output | 1 | One-cycle reset request |

## Verification
A refresh and the time-base edge that would finish the time-out can land on the same system clock edge. Software may kick the watchdog at the last possible moment. The bench provokes this by raising `refresh` exactly in the cycle where the synchronised edge of the final count is consumed. It judges the result in two ways: no request may appear at that point, and a fresh time-out measured from that edge must elapse in full before the next request. A second collision, between a tap-changing write and a count in progress, is judged the same way by the length of the following period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Time-out tap selection; each step multiplies the base period.
  typedef enum logic [1:0] {
    TAP_X1  = 2'b00,
    TAP_X2  = 2'b01,
    TAP_X4  = 2'b10,
    TAP_X16 = 2'b11
  } tap_sel_e;

  // Register layout: bit 4 source, bit 3 STOP run, bit 2 HALT run, [1:0] tap.
  typedef struct packed {
    logic     src_ext;
    logic     stop_run;
    logic     halt_run;
    tap_sel_e tap;
  } wdog_mode_t;

  localparam wdog_mode_t MODE_RESET = '{
    src_ext:  1'b0,
    stop_run: 1'b0,
    halt_run: 1'b1,
    tap:      TAP_X2
  };

  // Power-of-two exponent added to the base period for each tap.
  function automatic logic [2:0] tap_shift(input tap_sel_e t);
    case (t)
      TAP_X1:  return 3'd0;
      TAP_X2:  return 3'd1;
      TAP_X4:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  // Last sync stage high, edge-history stage low: one pulse per rising edge.
  assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       perm,
  input  logic       we,
  input  logic [4:0] wdata,
  output wdog_mode_t mode_q,
  output wdog_mode_t mode_eff,
  output logic       tap_clear
);

  wdog_mode_t nxt;

  assign nxt = wdog_mode_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst)     mode_q <= MODE_RESET;
    else if (we) mode_q <= nxt;
  end

  // Permanent mode: fixed tap, always runs in HALT, STOP gated by source only.
  always_comb begin
    if (perm) begin
      mode_eff.src_ext  = mode_q.src_ext;
      mode_eff.stop_run = 1'b1;
      mode_eff.halt_run = 1'b1;
      mode_eff.tap      = TAP_X2;
    end else begin
      mode_eff = mode_q;
    end
  end

  assign tap_clear = we && !perm && (nxt.tap != mode_q.tap);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int CNT_W     = BASE_LOG2 + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             perm,
  input  wdog_mode_t       mode_eff,
  input  logic             tick_int,
  input  logic             tick_ext,
  input  logic             halt,
  input  logic             stop,
  input  logic             refresh,
  input  logic             tap_clear,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             req
);

  localparam int SH_W = $clog2(CNT_W) + 1;

  logic             sel_tick;
  logic             run_ok;
  logic             step;
  logic [CNT_W-1:0] last;

  assign sel_tick = mode_eff.src_ext ? tick_ext : tick_int;

  // STOP gating takes precedence over HALT gating.
  always_comb begin
    if (stop)      run_ok = !mode_eff.src_ext && mode_eff.stop_run;
    else if (halt) run_ok = mode_eff.halt_run;
    else           run_ok = 1'b1;
  end

  assign step = armed && sel_tick && run_ok;
  assign last = (CNT_W'(1) << (SH_W'(BASE_LOG2) + SH_W'(tap_shift(mode_eff.tap))))
                - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= perm;
      cnt   <= '0;
      req   <= 1'b0;
    end else begin
      req <= 1'b0;
      if (refresh) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (tap_clear) begin
        cnt <= '0;
      end else if (step) begin
        if (cnt == last) begin
          req   <= 1'b1;
          cnt   <= '0;
          armed <= perm;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2   = 7,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = BASE_LOG2 + 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rc_clk_in,
  input  logic       ext_clk_in,
  input  logic       perm_strap,
  input  logic       refresh,
  input  logic       mode_we,
  input  logic [4:0] mode_wdata,
  input  logic       halt,
  input  logic       stop,
  output logic [4:0] mode_rdata,
  output logic       wdog_rst_req
);

  localparam int N_SRC = 2;

  logic [N_SRC-1:0] src_raw;
  logic [N_SRC-1:0] src_rise;
  wdog_mode_t       mode_q;
  wdog_mode_t       mode_eff;
  logic             tap_clear;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign src_raw = {ext_clk_in, rc_clk_in};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    wdog_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (src_raw[g]),
      .rise     (src_rise[g])
    );
  end

  wdog_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .perm      (perm_strap),
    .we        (mode_we),
    .wdata     (mode_wdata),
    .mode_q    (mode_q),
    .mode_eff  (mode_eff),
    .tap_clear (tap_clear)
  );

  wdog_core #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .perm      (perm_strap),
    .mode_eff  (mode_eff),
    .tick_int  (src_rise[0]),
    .tick_ext  (src_rise[1]),
    .halt      (halt),
    .stop      (stop),
    .refresh   (refresh),
    .tap_clear (tap_clear),
    .armed     (armed),
    .cnt       (cnt),
    .req       (wdog_rst_req)
  );

  assign mode_rdata = mode_q;

endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             perm_strap,
  input logic             refresh,
  input logic             mode_we,
  input logic             halt,
  input logic             stop,
  input logic [4:0]       mode_rdata,
  input logic             wdog_rst_req,
  input logic             armed,
  input logic [CNT_W-1:0] cnt
);

  assert_reset_mode_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mode_rdata == 5'b00101);

  assert_idle_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    (!armed && !perm_strap && !refresh && !mode_we) |=> $stable(cnt));

  assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (halt && !stop && !perm_strap && !mode_rdata[2] && !refresh && !mode_we)
      |=> $stable(cnt));

  assert_stop_ext_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (stop && mode_rdata[4] && !refresh && !mode_we) |=> $stable(cnt));

  assert_perm_armed_R8: assert property (@(posedge clk) disable iff (rst)
    perm_strap |-> armed);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_req |=> !wdog_rst_req);

  assert_refresh_wins_R11: assert property (@(posedge clk) disable iff (rst)
    refresh |=> !wdog_rst_req);

endmodule

bind wdog_ctl wdog_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .perm_strap   (perm_strap),
  .refresh      (refresh),
  .mode_we      (mode_we),
  .halt         (halt),
  .stop         (stop),
  .mode_rdata   (mode_rdata),
  .wdog_rst_req (wdog_rst_req),
  .armed        (armed),
  .cnt          (cnt)
);

// File: tb/wdog_ctl_test.sv
`timescale 1ns/1ps
module wdog_ctl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rc_clk_in = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic       perm_strap = 1'b0;
  logic       refresh = 1'b0;
  logic       mode_we = 1'b0;
  logic [4:0] mode_wdata = '0;
  logic       halt = 1'b0;
  logic       stop = 1'b0;
  logic [4:0] mode_rdata;
  logic       wdog_rst_req;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int wide_cnt = 0;
  bit prev_req = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_ctl uut (
    .clk          (clk),
    .rst          (rst),
    .rc_clk_in    (rc_clk_in),
    .ext_clk_in   (ext_clk_in),
    .perm_strap   (perm_strap),
    .refresh      (refresh),
    .mode_we      (mode_we),
    .mode_wdata   (mode_wdata),
    .halt         (halt),
    .stop         (stop),
    .mode_rdata   (mode_rdata),
    .wdog_rst_req (wdog_rst_req)
  );

  // Count request pulses and pulses wider than one cycle, sampled mid-cycle.
  always @(negedge clk) begin
    if (wdog_rst_req) req_cnt++;
    if (wdog_rst_req && prev_req) wide_cnt++;
    prev_req = wdog_rst_req;
  end

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input bit p);
    perm_strap = p;
    rst = 1'b1;
    refresh = 1'b0;
    mode_we = 1'b0;
    halt = 1'b0;
    stop = 1'b0;
    rc_clk_in = 1'b0;
    ext_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_mode(input logic [4:0] v);
    mode_we = 1'b1;
    mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic kick();
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
  endtask

  // One time-base edge. A refresh, if asked, lands on the edge where
  // the synchronised tick is consumed.
  task automatic tick(input bit ext, input bit refr, input int hold);
    if (ext) ext_clk_in = 1'b1; else rc_clk_in = 1'b1;
    repeat (hold) @(negedge clk);
    if (ext) ext_clk_in = 1'b0; else rc_clk_in = 1'b0;
    if (refr) refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n, input bit ext);
    for (int k = 0; k < n; k++) tick(ext, 1'b0, 2);
  endtask

  // {perm, halt, stop, mode[4:0], period[11:0] (0 = never), requirement[3:0]}
  localparam int NV = 14;
  localparam logic [23:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 5'b00000, 12'd128,  4'd3},  // R3 tap 00
    {1'b0, 1'b0, 1'b0, 5'b00001, 12'd256,  4'd3},  // R3 tap 01
    {1'b0, 1'b0, 1'b0, 5'b00010, 12'd512,  4'd3},  // R3 tap 10
    {1'b0, 1'b0, 1'b0, 5'b00011, 12'd2048, 4'd3},  // R3 tap 11
    {1'b0, 1'b0, 1'b0, 5'b10000, 12'd128,  4'd5},  // R5 external source
    {1'b0, 1'b1, 1'b0, 5'b00000, 12'd0,    4'd6},  // R6 frozen in HALT
    {1'b0, 1'b1, 1'b0, 5'b00100, 12'd128,  4'd6},  // R6 runs in HALT
    {1'b0, 1'b0, 1'b1, 5'b01000, 12'd128,  4'd7},  // R7 runs in STOP
    {1'b0, 1'b0, 1'b1, 5'b00000, 12'd0,    4'd7},  // R7 frozen in STOP
    {1'b0, 1'b0, 1'b1, 5'b11000, 12'd0,    4'd7},  // R7 external never in STOP
    {1'b0, 1'b1, 1'b1, 5'b01000, 12'd128,  4'd7},  // R7 STOP over HALT
    {1'b1, 1'b1, 1'b0, 5'b00000, 12'd256,  4'd8},  // R8 ignores tap and bit 2
    {1'b1, 1'b0, 1'b1, 5'b00000, 12'd256,  4'd8},  // R8 internal in STOP
    {1'b1, 1'b0, 1'b1, 5'b10000, 12'd0,    4'd8}   // R8 external in STOP
  };

  initial begin : watchdog
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int base;
    do_reset(1'b0);
    check(int'(mode_rdata), 5'b00101, "R4 reset mode value");
    check(int'(wdog_rst_req), 0, "R4 no request in reset state");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      bit          ext;
      int          per;
      v = VECS[i];
      do_reset(v[23]);
      write_mode(v[20:16]);
      halt = v[22];
      stop = v[21];
      ext = v[20];
      per = int'(v[15:4]);
      kick();
      base = req_cnt;
      if (per == 0) begin
        ticks(300, ext);
        check(req_cnt - base, 0, $sformatf("R%0d vector %0d never", v[3:0], i));
      end else begin
        ticks(per - 1, ext);
        check(req_cnt - base, 0, $sformatf("R%0d vector %0d early", v[3:0], i));
        ticks(1, ext);
        check(req_cnt - base, 1, $sformatf("R%0d vector %0d due", v[3:0], i));
      end
    end

    // R1: idle without refresh, idle again after a time-out
    do_reset(1'b0);
    base = req_cnt;
    ticks(300, 1'b0);
    check(req_cnt - base, 0, "R1 idle before refresh");
    kick();
    ticks(256, 1'b0);
    check(req_cnt - base, 1, "R4 default 256 period");
    ticks(300, 1'b0);
    check(req_cnt - base, 1, "R1 idle after time-out");

    // R5: unselected source ignored
    do_reset(1'b0);
    write_mode(5'b10000);
    kick();
    base = req_cnt;
    ticks(200, 1'b0);
    ticks(127, 1'b1);
    check(req_cnt - base, 0, "R5 internal edges ignored");
    ticks(1, 1'b1);
    check(req_cnt - base, 1, "R5 external edges counted");

    // R2: refresh restarts count
    do_reset(1'b0);
    write_mode(5'b00000);
    kick();
    base = req_cnt;
    ticks(100, 1'b0);
    kick();
    ticks(127, 1'b0);
    check(req_cnt - base, 0, "R2 restart after refresh");
    ticks(1, 1'b0);
    check(req_cnt - base, 1, "R2 full period after refresh");

    // R10: tap change clears, same-tap write does not
    do_reset(1'b0);
    write_mode(5'b00000);
    kick();
    base = req_cnt;
    ticks(100, 1'b0);
    write_mode(5'b00001);
    ticks(255, 1'b0);
    check(req_cnt - base, 0, "R10 tap change clears count");
    ticks(1, 1'b0);
    check(req_cnt - base, 1, "R10 new tap period");
    do_reset(1'b0);
    write_mode(5'b00000);
    kick();
    base = req_cnt;
    ticks(100, 1'b0);
    write_mode(5'b00100);
    ticks(27, 1'b0);
    check(req_cnt - base, 0, "R10 same tap keeps count early");
    ticks(1, 1'b0);
    check(req_cnt - base, 1, "R10 same tap keeps count due");

    // R11: refresh coincides with the final edge
    do_reset(1'b0);
    write_mode(5'b00000);
    kick();
    base = req_cnt;
    ticks(127, 1'b0);
    tick(1'b0, 1'b1, 2);
    check(req_cnt - base, 0, "R11 refresh wins over time-out");
    ticks(127, 1'b0);
    check(req_cnt - base, 0, "R11 count restarted");
    ticks(1, 1'b0);
    check(req_cnt - base, 1, "R11 next time-out");

    // R12: long-held edge counts once
    do_reset(1'b0);
    write_mode(5'b00000);
    kick();
    base = req_cnt;
    for (int k = 0; k < 127; k++) tick(1'b0, 1'b0, 9);
    check(req_cnt - base, 0, "R12 held level counts once");
    tick(1'b0, 1'b0, 9);
    check(req_cnt - base, 1, "R12 held level period");

    // R8: permanent mode armed from reset and re-arms
    do_reset(1'b1);
    base = req_cnt;
    ticks(256, 1'b0);
    check(req_cnt - base, 1, "R8 armed from reset");
    ticks(256, 1'b0);
    check(req_cnt - base, 2, "R8 stays armed");

    // R9: every request was a single cycle
    check(wide_cnt, 0, "R9 request width");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule